// File: doc/BRIEF.md
# Configurable-Mode SPI Master Shifter

This block is a single-lane serial master that runs from the system clock. A start strobe captures a transmit word, a character length, a clock divider and three mode controls: clock polarity, clock phase and bit order. It then produces that many serial clock pulses, shifts the word out on the data-out line and collects the data-in line into a received word.

The serial clock period is set in whole system clock cycles. Each pulse has an idle-level half and an active-level half. Phase selects which edge of a pulse moves the outgoing data and which edge samples the incoming line. The first outgoing bit is on the line before the first clock edge. Once a transfer has begun, every control input is ignored until the transfer ends with a one-cycle done pulse. The received word is presented with that pulse.

Top module: `spi_master_shifter`

## Requirements
- R1: For an effective divider D, every serial clock pulse spends floor(D/2) system cycles at the idle level followed by D - floor(D/2) cycles at the active level, so the period is D cycles.
- R2: After reset, busy_o and done_o are 0 and mosi_o is 0. Whenever no transfer runs, busy_o is 0, mosi_o is 0 and sclk_o equals cpol_i, following it while idle.
- R3: The leading edge of a pulse leaves the idle level and the trailing edge returns to it. With cpha_i = 0, data in is sampled on trailing edges and data out moves on every leading edge except the first. With cpha_i = 1, data in is sampled on leading edges and data out moves on every trailing edge except the last. For polarity 0 this puts phase 0 sampling on falling edges.
- R4: A start strobe accepted on a clock edge makes busy_o high after that edge. From then on, mosi_o already carries the first bit, before the first serial clock edge.
- R5: With lsb_first_i = 0 the word goes out and comes in from bit N-1 down to bit 0. With lsb_first_i = 1 it goes from bit 0 up to bit N-1. The k-th bit received lands in the same bit position as the k-th bit sent.
- R6: A transfer of effective length N produces exactly N serial clock pulses, and busy_o stays high for exactly N*D system cycles.
- R7: A start strobe while busy_o is high is ignored. No second transfer follows it and the running one is unchanged.
- R8: done_o is high for exactly one cycle, in the first cycle with busy_o low. rx_word_o then holds the received bits in its low N bits with zeros above, and keeps them until the next done pulse.
- R9: Polarity, phase, bit order, divider, length and transmit word are captured at start. Changing these inputs during a transfer has no effect on it.
- R10: A divider input below 2 acts as 2, and one above 256 acts as 256.
- R11: A length input below 2 acts as 2, and one above 16 acts as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| tx_word_i | input | MAX_LEN | Word to transmit |
| char_len_i | input | LEN_W | Bits per transfer, clamped to 2..MAX_LEN |
| clk_div_i | input | DIV_W | System cycles per serial clock period, clamped to 2..DIV_MAX |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on trailing edge; 1: sample on leading edge |
| lsb_first_i | input | 1 | 1: least significant bit first |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_word_o | output | MAX_LEN | Received word |

## Verification
The bench builds the block with its default parameters: MAX_LEN 16, LEN_W 5, DIV_W 9 and DIV_MAX 256. With a 5-bit length port, lengths of 1 and 20 can be driven, so both ends of the length clamp are reached. With a 9-bit divider port, values of 0, 1 and 300 can be driven around the 2..256 divider range. The full 256-cycle period at 16 bits fits in about four thousand cycles, so the longest transfer is measured pulse by pulse next to the shortest two-cycle period.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Mode bits captured at the start of a transfer.
    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spim_mode_t;

    // Kind of serial clock edge produced in the current system cycle.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LEAD  = 2'd1,
        EV_TRAIL = 2'd2
    } spim_edge_e;

    function automatic logic [31:0] clamp_u32(input logic [31:0] v,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
    import spim_pkg::*;
#(
    parameter int DIV_W = 9,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] half_lo,
    input  logic [DIV_W-1:0] half_hi,
    input  logic [LEN_W-1:0] len,
    output logic             run,
    output logic             active,
    output spim_edge_e       edge_kind,
    output logic             first_pulse,
    output logic             last_pulse,
    output logic             finish
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lo_q;
    logic [DIV_W-1:0] hi_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pcnt_q;
    logic             run_q;
    logic             act_q;
    logic             tick;

    assign tick        = run_q && (cnt_q == DIV_W'(1));
    assign first_pulse = (pcnt_q == '0);
    assign last_pulse  = (pcnt_q == len_q - 1'b1);
    assign finish      = tick && act_q && last_pulse;
    assign run         = run_q;
    assign active      = act_q;

    always_comb begin
        if (!tick)
            edge_kind = EV_NONE;
        else if (act_q)
            edge_kind = EV_TRAIL;
        else
            edge_kind = EV_LEAD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            act_q  <= 1'b0;
            cnt_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            len_q  <= '0;
            pcnt_q <= '0;
        end else if (load) begin
            run_q  <= 1'b1;
            act_q  <= 1'b0;
            cnt_q  <= half_lo;
            lo_q   <= half_lo;
            hi_q   <= half_hi;
            len_q  <= len;
            pcnt_q <= '0;
        end else if (tick) begin
            act_q <= ~act_q;
            cnt_q <= act_q ? lo_q : hi_q;
            if (act_q) begin
                pcnt_q <= pcnt_q + 1'b1;
                if (last_pulse)
                    run_q <= 1'b0;
            end
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R1: a running half never has an empty or overlong count
    assert_half_count_R1: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q != '0) && (cnt_q <= hi_q));

    // R6: pulse counter stays inside the programmed length
    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (pcnt_q < len_q));

    // R2: clock rests at the idle level once a transfer has ended
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !act_q);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [MAX_LEN-1:0] tx_word,
    input  logic [LEN_W-1:0]   len,
    input  spim_mode_t         mode,
    input  logic               busy,
    input  spim_edge_e         edge_kind,
    input  logic               first_pulse,
    input  logic               last_pulse,
    input  logic               miso,
    output logic               mosi,
    output logic [MAX_LEN-1:0] rx_next
);

    logic [MAX_LEN-1:0] word_q;
    logic [MAX_LEN-1:0] rx_q;
    logic [IDX_W-1:0]   idx_q;
    logic [LEN_W-1:0]   len_q;
    spim_mode_t         mode_q;
    logic               sample;
    logic               advance;

    always_comb begin
        if (mode_q.cpha) begin
            sample  = (edge_kind == EV_LEAD);
            advance = (edge_kind == EV_TRAIL) && !last_pulse;
        end else begin
            sample  = (edge_kind == EV_TRAIL);
            advance = (edge_kind == EV_LEAD) && !first_pulse;
        end
    end

    always_comb begin
        rx_next = rx_q;
        if (sample)
            rx_next[idx_q] = miso;
    end

    assign mosi = busy && word_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            rx_q   <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            mode_q <= '0;
        end else if (load) begin
            word_q <= tx_word;
            rx_q   <= '0;
            idx_q  <= mode.lsb_first ? '0 : IDX_W'(len - 1'b1);
            len_q  <= len;
            mode_q <= mode;
        end else begin
            rx_q <= rx_next;
            if (advance)
                idx_q <= mode_q.lsb_first ? idx_q + 1'b1 : idx_q - 1'b1;
        end
    end

    // R5: the bit pointer stays inside the active character
    assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (LEN_W'(idx_q) < len_q));

    // R9: mode and word held for the whole transfer
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(load)) |-> ($stable(mode_q) && $stable(word_q)));

endmodule

// File: rtl/spi_master_shifter.sv
module spi_master_shifter
    import spim_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5,
    parameter int DIV_W   = 9,
    parameter int DIV_MAX = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [MAX_LEN-1:0] tx_word_i,
    input  logic [LEN_W-1:0]   char_len_i,
    input  logic [DIV_W-1:0]   clk_div_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic               lsb_first_i,
    input  logic               miso_i,
    output logic               sclk_o,
    output logic               mosi_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [MAX_LEN-1:0] rx_word_o
);

    localparam int MIN_LEN = 2;
    localparam int MIN_DIV = 2;

    logic [LEN_W-1:0]   len_eff;
    logic [DIV_W-1:0]   div_eff;
    logic [DIV_W-1:0]   half_lo;
    logic [DIV_W-1:0]   half_hi;
    spim_mode_t         mode_in;
    logic               accept;
    logic               busy;
    logic               active;
    spim_edge_e         edge_kind;
    logic               first_pulse;
    logic               last_pulse;
    logic               finish;
    logic [MAX_LEN-1:0] rx_next;
    logic               pol_q;
    logic               done_q;
    logic [MAX_LEN-1:0] rx_q;

    assign len_eff = LEN_W'(clamp_u32(32'(char_len_i), 32'(MIN_LEN), 32'(MAX_LEN)));
    assign div_eff = DIV_W'(clamp_u32(32'(clk_div_i), 32'(MIN_DIV), 32'(DIV_MAX)));
    assign half_lo = div_eff >> 1;
    assign half_hi = div_eff - half_lo;
    assign mode_in = '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i};
    assign accept  = start_i && !busy;

    spim_clkgen #(
        .DIV_W (DIV_W),
        .LEN_W (LEN_W)
    ) u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .half_lo     (half_lo),
        .half_hi     (half_hi),
        .len         (len_eff),
        .run         (busy),
        .active      (active),
        .edge_kind   (edge_kind),
        .first_pulse (first_pulse),
        .last_pulse  (last_pulse),
        .finish      (finish)
    );

    spim_shifter #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_shifter (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .tx_word     (tx_word_i),
        .len         (len_eff),
        .mode        (mode_in),
        .busy        (busy),
        .edge_kind   (edge_kind),
        .first_pulse (first_pulse),
        .last_pulse  (last_pulse),
        .miso        (miso_i),
        .mosi        (mosi_o),
        .rx_next     (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= finish;
            if (accept)
                pol_q <= cpol_i;
            if (finish)
                rx_q <= rx_next;
        end
    end

    assign sclk_o    = busy ? (pol_q ^ active) : cpol_i;
    assign busy_o    = busy;
    assign done_o    = done_q;
    assign rx_word_o = rx_q;

    // R8: done lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R8: done coincides with the first idle cycle after a transfer
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy && $past(busy)));

    // R9: captured polarity holds while running
    assert_pol_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(pol_q));

    // R7: a strobe during a transfer never restarts the counters
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && !finish) |=> busy);

endmodule

// File: tb/sim_spi_master_shifter.sv
module sim_spi_master_shifter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic [4:0]  char_len_i = 5'd8;
    logic [8:0]  clk_div_i = 9'd4;
    logic        cpol_i = 1'b0;
    logic        cpha_i = 1'b0;
    logic        lsb_first_i = 1'b0;
    logic        miso_i = 1'b0;
    logic        sclk_o;
    logic        mosi_o;
    logic        busy_o;
    logic        done_o;
    logic [15:0] rx_word_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spi_master_shifter u0 (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .tx_word_i   (tx_word_i),
        .char_len_i  (char_len_i),
        .clk_div_i   (clk_div_i),
        .cpol_i      (cpol_i),
        .cpha_i      (cpha_i),
        .lsb_first_i (lsb_first_i),
        .miso_i      (miso_i),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rx_word_o   (rx_word_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic run_xfer(input logic [15:0] tx, input int len_in, input int div_in,
                            input bit pol, input bit pha, input bit lsb,
                            input logic [15:0] slv, input bit disturb, input string req);
        int  n = clampi(len_in, 2, 16);
        int  d = clampi(div_in, 2, 256);
        int  lo = d / 2;
        int  hi = d - lo;
        bit  prev = pol;
        bit  pm;
        bit  done_seen = 0;
        int  run = 0;
        int  pulses = 0;
        int  badhalf = 0;
        int  badbit = 0;
        int  sk = 0;
        int  si = 0;
        int  busyc = 0;
        int  it = 0;
        logic [15:0] rx = '0;
        logic [16:0] mask = (17'd1 << n) - 17'd1;

        @(negedge clk);
        tx_word_i   = tx;
        char_len_i  = len_in[4:0];
        clk_div_i   = div_in[8:0];
        cpol_i      = pol;
        cpha_i      = pha;
        lsb_first_i = lsb;
        miso_i      = slv[lsb ? 0 : n - 1];
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R4: first bit on the line before any clock edge
        check(busy_o === 1'b1, "R4", "busy after start", busy_o, 1);
        check(mosi_o === tx[lsb ? 0 : n - 1] && sclk_o === pol, "R4",
              "first bit before first edge", mosi_o, tx[lsb ? 0 : n - 1]);
        pm = mosi_o;
        while (it < 20000) begin
            bit s = sclk_o;
            if (s != prev) begin
                bit lead = (prev == pol);
                if (run != (lead ? lo : hi)) badhalf++;
                if (!lead) pulses++;
                if (pha ? lead : !lead) begin
                    if (sk < n && pm != tx[lsb ? sk : n - 1 - sk]) badbit++;
                    sk++;
                end
                if ((pha ? !lead : (lead && pulses > 0)) && si < n - 1) begin
                    si++;
                    miso_i = slv[lsb ? si : n - 1 - si];
                end
                run = 1;
                prev = s;
            end else begin
                run++;
            end
            if (busy_o) busyc++;
            if (done_o) begin
                done_seen = 1;
                rx = rx_word_o;
                break;
            end
            if (disturb && it == 2) begin
                tx_word_i   = ~tx;
                char_len_i  = 5'd3;
                clk_div_i   = 9'd9;
                cpha_i      = ~pha;
                lsb_first_i = ~lsb;
                start_i     = 1'b1;
            end
            if (disturb && it == 3) start_i = 1'b0;
            pm = mosi_o;
            it++;
            @(negedge clk);
        end
        check(done_seen, "R8", {req, " done seen"}, done_seen, 1);
        check(pulses == n, "R6", {req, " pulse count"}, pulses, n);
        check(busyc == n * d, "R6", {req, " busy cycles"}, busyc, n * d);
        check(badhalf == 0, "R1", {req, " half lengths"}, badhalf, 0);
        check(badbit == 0 && sk == n, "R3", {req, " mosi bits on sample edges"}, badbit, 0);
        check(rx == (slv & mask[15:0]), "R5", {req, " received word"}, rx, slv & mask[15:0]);
        @(negedge clk);
        check(done_o === 1'b0, "R8", {req, " done one cycle"}, done_o, 0);
        check(rx_word_o === rx, "R8", {req, " word held"}, rx_word_o, rx);
        check(sclk_o === pol && mosi_o === 1'b0, "R2", {req, " idle lines"}, sclk_o, pol);
        if (disturb) begin
            repeat (3) @(negedge clk);
            check(busy_o === 1'b0, "R7", {req, " no second transfer"}, busy_o, 0);
            tx_word_i = tx;
        end
    endtask

    task automatic t_reset;
        check(busy_o === 1'b0 && done_o === 1'b0, "R2", "reset busy/done", busy_o, 0);
        check(mosi_o === 1'b0 && sclk_o === 1'b0, "R2", "reset lines", mosi_o, 0);
    endtask

    task automatic t_idle_follow;
        @(negedge clk); cpol_i = 1'b1;
        @(negedge clk);
        check(sclk_o === 1'b1, "R2", "idle clock follows polarity 1", sclk_o, 1);
        cpol_i = 1'b0;
        @(negedge clk);
        check(sclk_o === 1'b0, "R2", "idle clock follows polarity 0", sclk_o, 0);
    endtask

    task automatic t_modes;
        run_xfer(16'h00A5, 8, 4, 0, 0, 0, 16'h003C, 0, "R3 mode00");
        run_xfer(16'h00C3, 8, 5, 0, 1, 1, 16'h0096, 0, "R3 mode01 R5 lsb");
        run_xfer(16'hB38E, 16, 2, 1, 0, 0, 16'h5A21, 0, "R3 mode10");
        run_xfer(16'h0E71, 12, 7, 1, 1, 1, 16'h0B4D, 0, "R3 mode11 R5 lsb");
    endtask

    task automatic t_clamps;
        run_xfer(16'h0002, 1, 0, 0, 0, 0, 16'h0001, 0, "R10 R11 low");
        run_xfer(16'h0001, 2, 1, 1, 0, 1, 16'h0002, 0, "R10 div1");
        run_xfer(16'h9C35, 20, 300, 0, 1, 0, 16'h6AC3, 0, "R10 R11 high");
    endtask

    task automatic t_disturb;
        run_xfer(16'h02D9, 10, 6, 0, 0, 0, 16'h0317, 1, "R7 R9 disturb");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_follow();
        t_modes();
        t_clamps();
        t_disturb();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule